// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Post-Shift Stage

This block is the combinational execute slice of a small microcoded datapath. It takes one operand from a holding register and a second operand from the source bus. A six-bit control word selects the operation. The result then passes through a fixed shifter before it drives the destination bus. There are no clocked elements inside, so a value applied at the inputs settles at the outputs in the same cycle.

The control word is made of independent fields: a gate for each operand, an invert on the held operand, a carry-in, and a two-bit function code. The function code picks AND, OR, complement of the bus operand, or a sum. Two flags describe the unshifted result, one for negative and one for zero. The shifter has three behaviours: pass the value through, shift it left by a byte with zero fill, or shift it right by one while keeping the sign. If both shift requests are raised together, the value passes through unshifted and a conflict output is raised.

Top module: `alu_shift_unit`

## Requirements
- R1: When `op_ctl[3]` is low the held operand is taken as zero. When `op_ctl[2]` is low the bus operand is taken as zero.
- R2: When `op_ctl[1]` is high the held operand is bitwise inverted after gating, so a gated-off and inverted operand is all ones.
- R3: Function code `op_ctl[5:4]` = 00 gives the bitwise AND of the two effective operands.
- R4: Function code 01 gives the bitwise OR of the two effective operands.
- R5: Function code 10 gives the bitwise complement of the effective bus operand.
- R6: Function code 11 gives the sum of the two effective operands plus `op_ctl[0]`, modulo 2^32. `op_ctl[0]` has no effect for the other function codes.
- R7: `neg_flag` equals bit 31 of the unshifted ALU value.
- R8: `zero_flag` is high exactly when all 32 bits of the unshifted ALU value are zero.
- R9: With only `shl_byte` high, `result` is the ALU value shifted left by 8 bits with zeros filled in.
- R10: With only `sar_one` high, `result` is the ALU value shifted right by 1 bit with bit 31 copied into the vacated position.
- R11: With neither shift request high, `result` equals the ALU value and `shift_conflict` is low.
- R12: With both shift requests high, `result` equals the unshifted ALU value and `shift_conflict` is high. `shift_conflict` is low in every other case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hold_opnd | input | 32 | Operand from the holding register |
| bus_opnd | input | 32 | Operand from the source bus |
| op_ctl | input | 6 | {fn[1:0], use_hold, use_bus, flip_hold, carry_in} |
| shl_byte | input | 1 | Request a logical left shift by 8 |
| sar_one | input | 1 | Request an arithmetic right shift by 1 |
| result | output | 32 | Shifted value driven to the destination bus |
| neg_flag | output | 1 | Sign of the unshifted ALU value |
| zero_flag | output | 1 | Unshifted ALU value is zero |
| shift_conflict | output | 1 | Both shift requests were raised together |

## Verification
The first stage is a set of directed vectors. They cover the usual microcode idioms: pass a single operand, increment, negate through invert plus carry, produce all ones, and produce all zeros. These separate the effects of the operand gates, the invert, and the carry-in. They also show that the carry-in is dropped outside the sum function. Sign-edge values are run through each shift mode. These distinguish a logical right shift from an arithmetic one, and they show that the flags are taken before the shift and not after. A long pseudo-random sweep then covers every control word and shift combination, including both shift requests at once, and compares each output against a behavioural model.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_SUM  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_BOTH  = 2'b11
  } shift_sel_e;

  // Layout matches the op_ctl port: [5:4] fn, [3] use_hold, [2] use_bus,
  // [1] flip_hold, [0] carry_in.
  typedef struct packed {
    alu_fn_e fn;
    logic    use_hold;
    logic    use_bus;
    logic    flip_hold;
    logic    carry_in;
  } alu_ctl_t;

  localparam int unsigned CTL_BITS = $bits(alu_ctl_t);

endpackage

// File: rtl/alu_operand_stage.sv
module alu_operand_stage
  import alu_shift_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] hold_raw,
  input  logic [WIDTH-1:0] bus_raw,
  input  logic             use_hold,
  input  logic             use_bus,
  input  logic             flip_hold,
  output logic [WIDTH-1:0] hold_eff,
  output logic [WIDTH-1:0] bus_eff
);

  logic [WIDTH-1:0] hold_gated;

  always_comb begin
    hold_gated = use_hold ? hold_raw : '0;
    hold_eff   = flip_hold ? ~hold_gated : hold_gated;
    bus_eff    = use_bus ? bus_raw : '0;
  end

  // R1 / R2: a gated-off operand yields only the constant the invert selects
  always_comb begin
    if (!use_hold) begin
      assert_gate_hold_R1: assert (hold_eff == {WIDTH{flip_hold}})
        else $error("held operand not gated");
    end
    if (!use_bus) begin
      assert_gate_bus_R1: assert (bus_eff == '0)
        else $error("bus operand not gated");
    end
  end

endmodule

// File: rtl/alu_logic_core.sv
module alu_logic_core
  import alu_shift_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  alu_fn_e          fn,
  input  logic             carry_in,
  output logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] CIN_ZERO_EXT = '0;

  logic [WIDTH-1:0] cin_vec;
  logic [WIDTH-1:0] sum_val;

  always_comb begin
    cin_vec    = CIN_ZERO_EXT;
    cin_vec[0] = carry_in;
    sum_val    = opa + opb + cin_vec;
  end

  always_comb begin
    unique case (fn)
      FN_AND:  value = opa & opb;
      FN_OR:   value = opa | opb;
      FN_NOTB: value = ~opb;
      FN_SUM:  value = sum_val;
      default: value = '0;
    endcase
  end

  // R5: complement of the bus operand is independent of the held operand
  always_comb begin
    if (fn == FN_NOTB) begin
      assert_notb_R5: assert ((value ^ opb) == '1)
        else $error("complement function wrong");
    end
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 8
) (
  input  logic [WIDTH-1:0] value,
  output logic             neg,
  output logic             zero
);

  localparam int unsigned NGROUPS = (WIDTH + GROUP - 1) / GROUP;
  localparam int unsigned PADDED  = NGROUPS * GROUP;

  logic [PADDED-1:0]  padded;
  logic [NGROUPS-1:0] group_any;

  always_comb begin
    padded             = '0;
    padded[WIDTH-1:0]  = value;
  end

  // Two-level zero detect: per-group OR, then a NOR over the groups.
  for (genvar g = 0; g < NGROUPS; g++) begin : g_zgrp
    assign group_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign zero = ~|group_any;
  assign neg  = value[WIDTH-1];

endmodule

// File: rtl/alu_post_shifter.sv
module alu_post_shifter
  import alu_shift_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned LEFT_AMT  = 8,
  parameter int unsigned RIGHT_AMT = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             want_left,
  input  logic             want_right,
  output logic [WIDTH-1:0] dout,
  output logic             conflict
);

  shift_sel_e       sel;
  logic [WIDTH-1:0] left_val;
  logic [WIDTH-1:0] right_val;

  always_comb begin
    sel       = shift_sel_e'({want_right, want_left});
    left_val  = din << LEFT_AMT;
    right_val = WIDTH'($signed(din) >>> RIGHT_AMT);
  end

  always_comb begin
    conflict = 1'b0;
    unique case (sel)
      SH_PASS:  dout = din;
      SH_LEFT:  dout = left_val;
      SH_RIGHT: dout = right_val;
      SH_BOTH: begin
        dout     = din;
        conflict = 1'b1;
      end
      default:  dout = din;
    endcase
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_shift_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned LEFT_AMT  = 8,
  parameter int unsigned RIGHT_AMT = 1
) (
  input  logic [WIDTH-1:0]    hold_opnd,
  input  logic [WIDTH-1:0]    bus_opnd,
  input  logic [CTL_BITS-1:0] op_ctl,
  input  logic                shl_byte,
  input  logic                sar_one,
  output logic [WIDTH-1:0]    result,
  output logic                neg_flag,
  output logic                zero_flag,
  output logic                shift_conflict
);

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] alu_val;

  assign ctl = alu_ctl_t'(op_ctl);

  alu_operand_stage #(.WIDTH(WIDTH)) u_opnd (
    .hold_raw  (hold_opnd),
    .bus_raw   (bus_opnd),
    .use_hold  (ctl.use_hold),
    .use_bus   (ctl.use_bus),
    .flip_hold (ctl.flip_hold),
    .hold_eff  (a_eff),
    .bus_eff   (b_eff)
  );

  alu_logic_core #(.WIDTH(WIDTH)) u_core (
    .opa      (a_eff),
    .opb      (b_eff),
    .fn       (ctl.fn),
    .carry_in (ctl.carry_in),
    .value    (alu_val)
  );

  alu_flag_gen #(.WIDTH(WIDTH), .GROUP(8)) u_flags (
    .value (alu_val),
    .neg   (neg_flag),
    .zero  (zero_flag)
  );

  alu_post_shifter #(
    .WIDTH     (WIDTH),
    .LEFT_AMT  (LEFT_AMT),
    .RIGHT_AMT (RIGHT_AMT)
  ) u_shift (
    .din        (alu_val),
    .want_left  (shl_byte),
    .want_right (sar_one),
    .dout       (result),
    .conflict   (shift_conflict)
  );

  // Checks across flag logic and shifter
  always_comb begin
    if (zero_flag) begin
      assert_zero_result_R8: assert (result == '0 && !neg_flag)
        else $error("zero flag with nonzero data");
    end
    if (!shl_byte && !sar_one) begin
      assert_pass_R11: assert (result == alu_val && !shift_conflict)
        else $error("pass mode altered value");
    end
    if (shl_byte && sar_one) begin
      assert_conflict_pass_R12: assert (result == alu_val && shift_conflict)
        else $error("conflict handling wrong");
    end
    if (shl_byte && !sar_one) begin
      assert_left_fill_R9: assert (result[LEFT_AMT-1:0] == '0 && !shift_conflict)
        else $error("left shift fill wrong");
    end
    if (sar_one && !shl_byte) begin
      assert_sign_keep_R10: assert (result[WIDTH-1] == neg_flag && !shift_conflict)
        else $error("arithmetic shift lost sign");
    end
  end

endmodule

// File: tb/alu_shift_unit_tb_top.sv
`timescale 1ns/1ps
module alu_shift_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] hold_opnd;
  logic [31:0] bus_opnd;
  logic [5:0]  op_ctl;
  logic        shl_byte;
  logic        sar_one;
  logic [31:0] result;
  logic        neg_flag;
  logic        zero_flag;
  logic        shift_conflict;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  alu_shift_unit dut_i (
    .hold_opnd      (hold_opnd),
    .bus_opnd       (bus_opnd),
    .op_ctl         (op_ctl),
    .shl_byte       (shl_byte),
    .sar_one        (sar_one),
    .result         (result),
    .neg_flag       (neg_flag),
    .zero_flag      (zero_flag),
    .shift_conflict (shift_conflict)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference
  function automatic longint unsigned ref_alu(input longint unsigned a, input longint unsigned b,
                                              input bit [5:0] c);
    longint unsigned ea, eb, r;
    longint unsigned m = 64'hFFFF_FFFF;
    ea = c[3] ? a : 0;
    if (c[1]) ea = m - ea;
    eb = c[2] ? b : 0;
    case (c[5:4])
      2'd0: r = ea & eb;
      2'd1: r = ea | eb;
      2'd2: r = m - eb;
      default: r = (ea + eb + c[0]) % 64'h1_0000_0000;
    endcase
    return r;
  endfunction

  function automatic longint unsigned ref_shift(input longint unsigned v, input bit l, input bit r);
    longint unsigned o;
    if (l && !r)      o = (v * 256) % 64'h1_0000_0000;
    else if (r && !l) begin
      o = v / 2;
      if (v >= 64'h8000_0000) o = o + 64'h8000_0000;
    end
    else              o = v;
    return o;
  endfunction

  function automatic string fn_tag(input bit [1:0] f);
    case (f)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string sh_tag(input bit l, input bit r);
    if (l && r) return "R12";
    if (l)      return "R9";
    if (r)      return "R10";
    return "R11";
  endfunction

  task automatic check(input string tag, input string what, input longint unsigned act,
                       input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input bit [31:0] a, input bit [31:0] b, input bit [5:0] c,
                       input bit l, input bit r, input string tag);
    longint unsigned v, s;
    @(posedge clk);
    hold_opnd = a; bus_opnd = b; op_ctl = c; shl_byte = l; sar_one = r;
    @(negedge clk);
    v = ref_alu(a, b, c);
    s = ref_shift(v, l, r);
    check({tag, "/", fn_tag(c[5:4]), "/", sh_tag(l, r)}, "result", result, s);
    check({tag, "/R7"}, "neg_flag", neg_flag, (v >= 64'h8000_0000) ? 1 : 0);
    check({tag, "/R8"}, "zero_flag", zero_flag, (v == 0) ? 1 : 0);
    check({tag, "/R12"}, "shift_conflict", shift_conflict, (l && r) ? 1 : 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] lcg;
    lcg = 32'h1234_5678;
    rst_n = 1'b0;
    hold_opnd = '0; bus_opnd = '0; op_ctl = '0; shl_byte = 1'b0; sar_one = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset/R8", "result", result, 0);
    check("reset/R8", "zero_flag", zero_flag, 1);
    check("reset/R12", "shift_conflict", shift_conflict, 0);

    // op_ctl = {fn[1:0], use_hold, use_bus, flip_hold, carry_in}
    apply(32'hDEAD_BEEF, 32'h0000_0000, 6'b11_1000, 0, 0, "R1 pass hold");
    apply(32'hDEAD_BEEF, 32'h1357_9BDF, 6'b11_0100, 0, 0, "R1 pass bus");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b11_0000, 0, 0, "R1 both gated");
    apply(32'h1234_5678, 32'h0,         6'b11_0010, 0, 0, "R2 gated invert ones");
    apply(32'h0000_0005, 32'h0,         6'b11_1011, 0, 0, "R2 R6 negate");
    apply(32'h0,         32'h7FFF_FFFF, 6'b11_0101, 0, 0, "R6 increment to sign");
    apply(32'hFFFF_FFFF, 32'h0000_0001, 6'b11_1100, 0, 0, "R6 wrap to zero");
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 6'b00_1101, 0, 0, "R3 carry ignored");
    apply(32'hF0F0_F0F0, 32'h0F00_0F00, 6'b01_1101, 0, 0, "R4 carry ignored");
    apply(32'hAAAA_AAAA, 32'h0000_FFFF, 6'b10_1101, 0, 0, "R5 carry ignored");
    apply(32'h8000_0001, 32'h0,         6'b11_1000, 0, 1, "R10 sign copy");
    apply(32'h4000_0001, 32'h0,         6'b11_1000, 0, 1, "R10 positive");
    apply(32'h8100_00FF, 32'h0,         6'b11_1000, 1, 0, "R9 R7 flag before shift");
    apply(32'h0100_0000, 32'h0,         6'b11_1000, 1, 0, "R9 R8 nonzero shifts out");
    apply(32'h8000_0001, 32'h0,         6'b11_1000, 1, 1, "R12 both requests");

    for (int i = 0; i < 3000; i++) begin
      bit [31:0] a, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223; b = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:29] == 3'd0) b = ~a;
      apply(a, b, lcg[5:0], lcg[8], lcg[9], "sweep");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule